// File: doc/BRIEF.md
# Cascaded Alpha Blend Compositor

This block merges up to four streamed image layers over a flat, fully opaque background colour and produces one composed raster stream. It walks the output frame in raster order and runs each output pixel through a fixed chain of blend stages. The first stage blends layer 0 over the background. Each later stage blends the next layer over the result of the stage before it. Layer 3 therefore ends up on top. Every pixel is a 32-bit word with alpha in bits [31:24] and three 8-bit colour channels below it. The channel meaning (RGB or YUV) does not matter, because all ports carry the same format and nothing is converted.

Each layer has an enable flag, a premultiplied-alpha flag, a top-left position and a size. Its pixels arrive on a valid/ready stream that carries only the part of the layer that falls inside the output frame, in raster order. Layer streams and the output stream follow valid/ready rules. A transfer takes place on a rising edge where both valid and ready are high. The design never asserts `in_ready` for a layer unless it needs a pixel from that layer for the current output position. While `out_valid` is high and `out_ready` is low, the output word and its markers hold still and the whole pipeline stalls. The configuration pins are plain levels and must stay stable while a frame is streaming. Configuration is changed under reset.

Top module: `alpha_compositor`

## Requirements
- R1: With no layer covering a pixel, the output word is {0xFF, bg_color}.
- R2: Layer i is blended in stage i, with stage i taking the output of stage i−1 as its destination. The four layers are therefore stacked with layer 3 uppermost.
- R3: For a straight-alpha source, each colour channel becomes sat255(rnd(D·(255−Sa)/255) + rnd(S·Sa/255)). Here rnd is rounding to nearest and sat255 clamps at 255. A source with alpha 0xFF replaces the pixel with {0xFF, source colour}.
- R4: For a source flagged premultiplied, each colour channel becomes sat255(rnd(D·(255−Sa)/255) + S).
- R5: In both modes, the output alpha is sat255(rnd(Da·(255−Sa)/255) + Sa). A stage never lowers the alpha of its destination.
- R6: A disabled layer has no effect on the output, whatever its in_valid and in_data do, and its in_ready stays low.
- R7: A layer covers the columns [px, px+w) and rows [py, py+h), cut at the frame edge. A size of 0 counts as 1. Outside that window the stage passes its destination unchanged. The layer stream supplies exactly the visible pixels of each frame, in raster order.
- R8: Layer positions are clamped to px ≤ W−1 and py ≤ H−1. The layer keeps its own size.
- R9: Frame width and height are each clamped to the range 1 to 8190. A value of 0 acts as 1, and 8191 acts as 8190.
- R10: out_sof is high on the first pixel of each frame (column 0, row 0). out_eol is high on the last pixel of each row.
- R11: While out_valid is high and out_ready is low, out_data, out_sof and out_eol stay unchanged and no layer pixel is consumed.
- R12: After reset, out_valid and all in_ready are low. With out_ready high and no layer needed, the first output appears NUM_LAYERS+1 clock edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bg_color | input | 24 | Background colour, alpha forced opaque |
| frame_w | input | CW | Output frame width, clamped 1..MAX_DIM |
| frame_h | input | CW | Output frame height, clamped 1..MAX_DIM |
| layer_en | input | NUM_LAYERS | Per-layer enable |
| layer_premul | input | NUM_LAYERS | Per-layer premultiplied-alpha flag |
| layer_x | input | NUM_LAYERS*CW | Per-layer left column, layer i in bits [i*CW +: CW] |
| layer_y | input | NUM_LAYERS*CW | Per-layer top row |
| layer_w | input | NUM_LAYERS*CW | Per-layer width |
| layer_h | input | NUM_LAYERS*CW | Per-layer height |
| in_valid | input | NUM_LAYERS | Layer pixel valid |
| in_ready | output | NUM_LAYERS | Layer pixel accepted |
| in_data | input | NUM_LAYERS*32 | Layer pixels, layer i in bits [i*32 +: 32] |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take a pixel |
| out_data | output | 32 | Composed pixel {alpha, c2, c1, c0} |
| out_sof | output | 1 | First pixel of frame |
| out_eol | output | 1 | Last pixel of row |

## Verification
The bench places layers far outside the frame and gives some layers zero size. A design that fails to clamp positions or sizes would read the wrong number of layer pixels, and every later frame would slip out of step. Source alphas of 0 and 0xFF are mixed with premultiplied colours above alpha, which drives the saturating sum and the rounding. A design that truncates instead of rounding, or wraps instead of saturating, gives channels that differ by one or by wrapping. Disabled layers are driven with random valid pulses, so a design that listens to them would either consume their stream or corrupt the image. Frame widths of 0 and 8191, together with random back-pressure, check the limits, the eol placement and that held outputs stay still.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  localparam int CH_W = 8;
  localparam int PIX_W = 4 * CH_W;

  typedef struct packed {
    logic [CH_W-1:0] a;
    logic [CH_W-1:0] c2;
    logic [CH_W-1:0] c1;
    logic [CH_W-1:0] c0;
  } pixel_t;

  // Rounded p/255 for p in 0..255*255
  function automatic logic [7:0] div255(input logic [15:0] p);
    logic [16:0] t;
    logic [16:0] u;
    t = {1'b0, p} + 17'd128;
    u = t + (t >> 8);
    return 8'(u >> 8);
  endfunction

  function automatic logic [7:0] sat_add(input logic [7:0] x, input logic [7:0] y);
    logic [8:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[8] ? 8'hFF : s[7:0];
  endfunction

  function automatic logic [7:0] mix_ch(input logic [7:0] dc, input logic [7:0] sc,
                                        input logic [7:0] sa, input logic pm);
    logic [7:0] keep;
    logic [7:0] add;
    keep = div255(16'(dc) * 16'(8'hFF - sa));
    add  = pm ? sc : div255(16'(sc) * 16'(sa));
    return sat_add(keep, add);
  endfunction

  function automatic pixel_t blend_px(input pixel_t d, input pixel_t s, input logic pm);
    pixel_t r;
    r.a  = sat_add(div255(16'(d.a) * 16'(8'hFF - s.a)), s.a);
    r.c2 = mix_ch(d.c2, s.c2, s.a, pm);
    r.c1 = mix_ch(d.c1, s.c1, s.a, pm);
    r.c0 = mix_ch(d.c0, s.c0, s.a, pm);
    return r;
  endfunction

endpackage

// File: rtl/cmp_raster.sv
module cmp_raster #(
  parameter int MAX_DIM = 8190,
  parameter int CW      = $clog2(MAX_DIM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [CW-1:0] frame_w,
  input  logic [CW-1:0] frame_h,
  output logic [CW-1:0] x,
  output logic [CW-1:0] y,
  output logic [CW-1:0] w_eff,
  output logic [CW-1:0] h_eff,
  output logic          sof,
  output logic          eol
);
  localparam logic [CW-1:0] DIM_HI = CW'(MAX_DIM);

  function automatic logic [CW-1:0] clamp_dim(input logic [CW-1:0] v);
    if (v == '0)     return CW'(1);
    if (v > DIM_HI)  return DIM_HI;
    return v;
  endfunction

  logic [CW-1:0] x_q, y_q;
  logic          last_col, last_row;

  assign w_eff    = clamp_dim(frame_w);
  assign h_eff    = clamp_dim(frame_h);
  assign last_col = (x_q >= w_eff - CW'(1));
  assign last_row = (y_q >= h_eff - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (adv) begin
      if (last_col) begin
        x_q <= '0;
        y_q <= last_row ? '0 : y_q + CW'(1);
      end else begin
        x_q <= x_q + CW'(1);
      end
    end
  end

  assign x   = x_q;
  assign y   = y_q;
  assign sof = (x_q == '0) && (y_q == '0);
  assign eol = last_col;

  a_r9_scan_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (x_q < w_eff) && (y_q < h_eff));

endmodule

// File: rtl/cmp_window.sv
module cmp_window #(
  parameter int CW = 13
) (
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  logic [CW-1:0] pos_x,
  input  logic [CW-1:0] pos_y,
  input  logic [CW-1:0] size_w,
  input  logic [CW-1:0] size_h,
  input  logic [CW-1:0] w_eff,
  input  logic [CW-1:0] h_eff,
  output logic          hit
);
  logic [CW-1:0] px, py, sw, sh;
  logic          in_x, in_y;

  always_comb begin
    px = (pos_x > w_eff - CW'(1)) ? w_eff - CW'(1) : pos_x;
    py = (pos_y > h_eff - CW'(1)) ? h_eff - CW'(1) : pos_y;
    sw = (size_w == '0) ? CW'(1) : size_w;
    sh = (size_h == '0) ? CW'(1) : size_h;
    in_x = (x >= px) && ((x - px) < sw);
    in_y = (y >= py) && ((y - py) < sh);
    hit  = in_x && in_y;
  end

endmodule

// File: rtl/cmp_blend_stage.sv
module cmp_blend_stage
  import cmp_pkg::*;
#(
  parameter int SB_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            in_valid,
  input  pixel_t          in_dst,
  input  pixel_t          in_src,
  input  logic            in_use,
  input  logic            premul,
  input  logic [SB_W-1:0] in_sb,
  output logic            out_valid,
  output pixel_t          out_dst,
  output logic [SB_W-1:0] out_sb
);
  pixel_t mixed;

  always_comb mixed = in_use ? blend_px(in_dst, in_src, premul) : in_dst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (en) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      out_dst <= mixed;
      out_sb  <= in_sb;
    end
  end

  // R6 / R7: a stage with no source passes the destination through
  a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en && in_valid && !in_use) |-> out_dst == $past(in_dst));

  // R5: alpha never decreases through a stage
  a_r5_alpha_grows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en && in_valid) |-> out_dst.a >= $past(in_dst.a));

  // R3: an opaque source replaces the pixel
  a_r3_opaque_src: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en && in_valid && in_use && in_src.a == 8'hFF)
      |-> out_dst == {8'hFF, $past(in_src[23:0])});

endmodule

// File: rtl/alpha_compositor.sv
module alpha_compositor
  import cmp_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  parameter int MAX_DIM    = 8190,
  parameter int CW         = $clog2(MAX_DIM + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [23:0]                 bg_color,
  input  logic [CW-1:0]               frame_w,
  input  logic [CW-1:0]               frame_h,
  input  logic [NUM_LAYERS-1:0]       layer_en,
  input  logic [NUM_LAYERS-1:0]       layer_premul,
  input  logic [NUM_LAYERS*CW-1:0]    layer_x,
  input  logic [NUM_LAYERS*CW-1:0]    layer_y,
  input  logic [NUM_LAYERS*CW-1:0]    layer_w,
  input  logic [NUM_LAYERS*CW-1:0]    layer_h,
  input  logic [NUM_LAYERS-1:0]       in_valid,
  output logic [NUM_LAYERS-1:0]       in_ready,
  input  logic [NUM_LAYERS*PIX_W-1:0] in_data,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [PIX_W-1:0]            out_data,
  output logic                        out_sof,
  output logic                        out_eol
);
  localparam int LAST = NUM_LAYERS - 1;
  localparam int TAP_W = PIX_W + 1;

  logic                  en, avail, fire;
  logic [CW-1:0]         x, y, w_eff, h_eff;
  logic                  sof, eol;
  logic [NUM_LAYERS-1:0] hit, need;

  // Fetch register
  logic                        f_valid;
  logic [NUM_LAYERS-1:0]       f_use;
  logic [NUM_LAYERS*PIX_W-1:0] f_src;
  logic [1:0]                  f_mark;

  // Stage chain
  logic       st_vin  [NUM_LAYERS];
  pixel_t     st_din  [NUM_LAYERS];
  logic [1:0] st_min  [NUM_LAYERS];
  logic       st_vout [NUM_LAYERS];
  pixel_t     st_dout [NUM_LAYERS];
  logic [1:0] st_mout [NUM_LAYERS];
  logic [TAP_W-1:0] tap [NUM_LAYERS];

  assign en = !out_valid || out_ready;

  cmp_raster #(.MAX_DIM(MAX_DIM), .CW(CW)) u_raster (
    .clk(clk), .rst_n(rst_n), .adv(fire),
    .frame_w(frame_w), .frame_h(frame_h),
    .x(x), .y(y), .w_eff(w_eff), .h_eff(h_eff),
    .sof(sof), .eol(eol)
  );

  for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_win
    cmp_window #(.CW(CW)) u_win (
      .x(x), .y(y),
      .pos_x(layer_x[i*CW +: CW]), .pos_y(layer_y[i*CW +: CW]),
      .size_w(layer_w[i*CW +: CW]), .size_h(layer_h[i*CW +: CW]),
      .w_eff(w_eff), .h_eff(h_eff),
      .hit(hit[i])
    );
    assign need[i] = layer_en[i] && hit[i];

    // R6: only enabled, offered layers are ever accepted
    a_r6_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready[i] |-> layer_en[i] && in_valid[i]);
  end

  assign avail    = &(~need | in_valid);
  assign fire     = en && avail;
  assign in_ready = need & {NUM_LAYERS{fire}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) f_valid <= 1'b0;
    else if (en) f_valid <= fire;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      f_use  <= need;
      f_src  <= in_data;
      f_mark <= {sof, eol};
    end
  end

  // Source delay lines: layer k waits k extra cycles for its stage
  for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_tap
    if (k == 0) begin : g_direct
      assign tap[k] = {f_use[k], f_src[k*PIX_W +: PIX_W]};
    end else begin : g_delay
      logic [TAP_W-1:0] dl [k];
      always_ff @(posedge clk) begin
        if (en) begin
          dl[0] <= {f_use[k], f_src[k*PIX_W +: PIX_W]};
          for (int d = 1; d < k; d++) dl[d] <= dl[d-1];
        end
      end
      assign tap[k] = dl[k-1];
    end
  end

  for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign st_vin[k] = f_valid;
      assign st_din[k] = pixel_t'({8'hFF, bg_color});
      assign st_min[k] = f_mark;
    end else begin : g_link
      assign st_vin[k] = st_vout[k-1];
      assign st_din[k] = st_dout[k-1];
      assign st_min[k] = st_mout[k-1];
    end

    cmp_blend_stage #(.SB_W(2)) u_stage (
      .clk(clk), .rst_n(rst_n), .en(en),
      .in_valid(st_vin[k]), .in_dst(st_din[k]),
      .in_src(pixel_t'(tap[k][PIX_W-1:0])), .in_use(tap[k][PIX_W]),
      .premul(layer_premul[k]), .in_sb(st_min[k]),
      .out_valid(st_vout[k]), .out_dst(st_dout[k]), .out_sb(st_mout[k])
    );
  end

  assign out_valid = st_vout[LAST];
  assign out_data  = st_dout[LAST];
  assign out_sof   = st_mout[LAST][1];
  assign out_eol   = st_mout[LAST][0];

  // R11: held output stays put under back-pressure
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                               && $stable(out_sof) && $stable(out_eol));

  // R11: nothing is consumed while the output is blocked
  a_r11_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> in_ready == '0);

endmodule

// File: tb/alpha_compositor_tb_top.sv
module alpha_compositor_tb_top;
  localparam int NL = 4;
  localparam int CW = 13;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic [23:0]      bg;
  logic [CW-1:0]    fw, fh;
  logic [NL-1:0]    len, lpm;
  logic [NL*CW-1:0] lx, ly, lw, lh;
  logic [NL-1:0]    ivalid, iready;
  logic [NL*32-1:0] idata;
  logic             ovalid, oready, osof, oeol;
  logic [31:0]      odata;
  logic [31:0]      salt;

  int  checks = 0, errors = 0, cyc = 0;
  bit  timeout = 0;

  always @(posedge clk) cyc++;

  alpha_compositor #(.NUM_LAYERS(NL), .MAX_DIM(8190), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bg_color(bg), .frame_w(fw), .frame_h(fh),
    .layer_en(len), .layer_premul(lpm),
    .layer_x(lx), .layer_y(ly), .layer_w(lw), .layer_h(lh),
    .in_valid(ivalid), .in_ready(iready), .in_data(idata),
    .out_valid(ovalid), .out_ready(oready), .out_data(odata),
    .out_sof(osof), .out_eol(oeol)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic int eff(int v);
    if (v == 0) return 1;
    if (v > 8190) return 8190;
    return v;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [31:0] lpix(int i, int k);
    logic [31:0] h;
    h = (32'(k) * 32'd2654435761) ^ (32'(i) * 32'h9E37) ^ salt;
    h = h ^ (h >> 13);
    h = h * 32'd1103515245;
    if (k % 5 == 0) h[31:24] = 8'h00;
    if (k % 5 == 1) h[31:24] = 8'hFF;
    return h;
  endfunction

  function automatic int r255(int p);
    return (p + 127) / 255;
  endfunction

  function automatic logic [31:0] bblend(logic [31:0] d, logic [31:0] s, bit pm);
    logic [31:0] r;
    int sa, v, dc, sc;
    sa = int'(s[31:24]);
    v = r255(int'(d[31:24]) * (255 - sa)) + sa;
    r[31:24] = 8'(imin(v, 255));
    for (int c = 0; c < 3; c++) begin
      dc = int'(d[c*8 +: 8]);
      sc = int'(s[c*8 +: 8]);
      v = r255(dc * (255 - sa)) + (pm ? sc : r255(sc * sa));
      r[c*8 +: 8] = 8'(imin(v, 255));
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_pix(int x, int y, int fr);
    logic [31:0] d;
    int we, he, px, py, sw, sh, vw, vh, k;
    d = {8'hFF, bg};
    we = eff(int'(fw));
    he = eff(int'(fh));
    for (int i = 0; i < NL; i++) begin
      if (len[i]) begin
        px = imin(int'(lx[i*CW +: CW]), we - 1);
        py = imin(int'(ly[i*CW +: CW]), he - 1);
        sw = (lw[i*CW +: CW] == 0) ? 1 : int'(lw[i*CW +: CW]);
        sh = (lh[i*CW +: CW] == 0) ? 1 : int'(lh[i*CW +: CW]);
        vw = imin(sw, we - px);
        vh = imin(sh, he - py);
        if (x >= px && x < px + vw && y >= py && y < py + vh) begin
          k = fr * vw * vh + (y - py) * vw + (x - px);
          d = bblend(d, lpix(i, k), lpm[i]);
        end
      end
    end
    return d;
  endfunction

  task automatic set_layer(int i, bit e, bit pm, int x, int y, int w, int h);
    len[i] = e;
    lpm[i] = pm;
    lx[i*CW +: CW] = CW'(x);
    ly[i*CW +: CW] = CW'(y);
    lw[i*CW +: CW] = CW'(w);
    lh[i*CW +: CW] = CW'(h);
  endtask

  task automatic clear_layers();
    for (int i = 0; i < NL; i++) set_layer(i, 0, 0, 0, 0, 1, 1);
  endtask

  task automatic run(string tag, int nframes, bit lat);
    int we, he, total, ox, oy, fr, got;
    bit took [NL];
    int cnt [NL];
    bit prev_hold, ready_bad;
    logic [31:0] prev_data, e;
    logic [1:0] prev_mark;
    we = eff(int'(fw));
    he = eff(int'(fh));
    total = we * he * nframes;
    ox = 0; oy = 0; fr = 0; got = 0;
    prev_hold = 0; ready_bad = 0; prev_data = '0; prev_mark = '0;
    for (int i = 0; i < NL; i++) begin
      took[i] = 0;
      cnt[i] = 0;
    end
    rst_n = 1'b0;
    ivalid = '0;
    oready = lat;
    repeat (2) @(negedge clk);
    // R12 reset state
    chk(ovalid == 1'b0 && iready == '0, "R12 reset idle", {27'd0, iready, ovalid}, 32'd0);
    rst_n = 1'b1;
    if (lat) begin
      repeat (NL) @(negedge clk);
      chk(ovalid == 1'b0, "R12 latency early", {31'd0, ovalid}, 32'd0);
      @(negedge clk);
      chk(ovalid == 1'b1, "R12 latency", {31'd0, ovalid}, 32'd1);
    end
    while (got < total && !timeout) begin
      for (int i = 0; i < NL; i++) begin
        if (took[i]) cnt[i]++;
        if (!ivalid[i] || took[i]) begin
          ivalid[i] = len[i] ? ($urandom % 4 != 0) : ($urandom % 2 == 0);
          idata[i*32 +: 32] = lpix(i, cnt[i]);
        end
      end
      oready = ($urandom % 4 != 0);
      #1;
      for (int i = 0; i < NL; i++) begin
        took[i] = ivalid[i] && iready[i];
        if (iready[i] && !len[i]) ready_bad = 1;
      end
      if (prev_hold)
        chk(ovalid && odata == prev_data && {osof, oeol} == prev_mark,
            "R11 hold", odata, prev_data);
      if (ovalid && oready) begin
        e = exp_pix(ox, oy, fr);
        chk(odata == e, tag, odata, e);
        chk(osof == (ox == 0 && oy == 0) && oeol == (ox == we - 1), "R10 markers",
            {30'd0, osof, oeol}, {30'd0, 1'(ox == 0 && oy == 0), 1'(ox == we - 1)});
        got++;
        if (ox == we - 1) begin
          ox = 0;
          if (oy == he - 1) begin
            oy = 0;
            fr++;
          end else oy++;
        end else ox++;
      end
      prev_hold = ovalid && !oready;
      prev_data = odata;
      prev_mark = {osof, oeol};
      @(negedge clk);
      if (cyc > LIMIT) timeout = 1;
    end
    chk(!ready_bad, "R6 disabled ready", {31'd0, ready_bad}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0;
    ivalid = '0;
    oready = 1'b0;
    idata = '0;
    salt = 32'h1234_5678;
    bg = 24'h204060;
    fw = CW'(5);
    fh = CW'(3);
    clear_layers();
    @(negedge clk);

    // R1 background only, plus R12 latency
    bg = 24'hA1B2C3;
    run("R1 background", 2, 1);

    // R3 straight alpha, single full-frame layer
    clear_layers();
    fw = CW'(4); fh = CW'(2); salt = 32'h0BAD_F00D;
    set_layer(0, 1, 0, 0, 0, 4, 2);
    run("R3 straight", 2, 0);

    // R4 premultiplied layer
    clear_layers();
    set_layer(2, 1, 1, 1, 0, 3, 2);
    run("R4 premul", 2, 0);

    // R7 R8 windowing and position clamp
    clear_layers();
    fw = CW'(6); fh = CW'(4); salt = 32'h5151_A0A0;
    set_layer(0, 1, 0, 50, 50, 3, 3);
    set_layer(1, 1, 1, 2, 1, 0, 0);
    set_layer(3, 1, 0, 4, 0, 7, 2);
    run("R7 R8 window", 3, 0);

    // R2 all four stacked
    clear_layers();
    fw = CW'(3); fh = CW'(3); bg = 24'h0F0F0F;
    for (int i = 0; i < NL; i++) set_layer(i, 1, i % 2, 0, 0, 3, 3);
    run("R2 stack order", 2, 0);

    // R9 width 0 and width above the limit
    clear_layers();
    fw = CW'(0); fh = CW'(3);
    set_layer(1, 1, 0, 0, 1, 2, 2);
    run("R9 zero width", 1, 0);
    clear_layers();
    fw = CW'(8191); fh = CW'(1);
    set_layer(0, 1, 0, 8191, 0, 4, 1);
    set_layer(1, 1, 1, 8185, 0, 13, 1);
    run("R9 max width", 1, 0);

    // R5 random scenarios
    for (int s = 0; s < 40 && !timeout; s++) begin
      fw = CW'(1 + $urandom % 12);
      fh = CW'(1 + $urandom % 10);
      bg = 24'($urandom);
      salt = $urandom;
      for (int i = 0; i < NL; i++)
        set_layer(i, $urandom % 4 != 0, $urandom % 2, $urandom % 14, $urandom % 12,
                  $urandom % 9, $urandom % 9);
      run("R5 random", 2, 0);
    end

    if (timeout) chk(0, "watchdog", cyc, LIMIT);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule